// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller connects a small 8-bit processor core to external memories over a 16-bit address space. The pin budget is tight. The upper address byte has a dedicated output port. The lower address byte and the data byte share one port, and an address-latch strobe tells the two apart. An external latch catches the low address while that strobe is high, and after that the shared port carries data. Program memory and data memory each have a full address space of their own. They are told apart only by which active-low strobe is pulsed: a program-fetch strobe for code, and separate read and write strobes for data.

The core issues one of three operations: code fetch, data read or data write. It then waits for a single-cycle completion pulse, which comes with the read byte where there is one. A mode pin decides where code fetches go. With the pin low, every fetch goes out on the external bus. With the pin high, fetches below the on-chip ROM size (4 KB by default) go to an internal ROM port with a request/acknowledge handshake, and higher addresses go out on the external bus. Data accesses always use the external bus.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `ale` is low, `psen_n`, `rd_n` and `wr_n` are high, `ad_oe`, `done` and `rom_req` are low.
- R2: In the cycle after an external request is accepted, `ale` is high for exactly one cycle with `ad_oe` high, `ad_out` equal to address bits 7:0 and `addr_hi` equal to address bits 15:8; `addr_hi` keeps that value until the access ends.
- R3: `req_op` encoding: 0 is a code fetch and pulses `psen_n`, 1 is a data read and pulses `rd_n`, 2 is a data write and pulses `wr_n`, and 3 is reserved and ignored, with no pin activity, no ROM request and no `done`.
- R4: At most one of `psen_n`, `rd_n`, `wr_n` is low in any cycle. The strobe stays low for exactly `STRB_LEN` cycles. It starts in the cycle right after the `ale` cycle for fetches and reads, and two cycles after it for writes.
- R5: `ale` is never high in a cycle where any strobe is low.
- R6: During a fetch or read strobe, `ad_oe` is low. `rdata` takes the value of `ad_in` at the last clock edge of the strobe-low period, and `done` is high in the following cycle, which is the single strobe-high recovery cycle.
- R7: For a write, `ad_out` carries the write byte with `ad_oe` high in the cycle before `wr_n` falls, through the strobe, and in the recovery cycle after `wr_n` rises. `done` is high in that recovery cycle, and `ad_oe` is low in the cycle after it.
- R8: With `ea_pin` low when a fetch is accepted, the fetch uses the external bus at every address.
- R9: With `ea_pin` high, a fetch below 0x1000 raises `rom_req` in the next cycle with `rom_addr` equal to address bits 11:0, and there is no external pin activity. `rom_req` and `rom_addr` hold until `rom_ack`. `rdata` takes `rom_data` at the acknowledging edge, and `done` is high in the next cycle.
- R10: With `ea_pin` high, a fetch at 0x1000 or above uses the external bus. Data reads and writes use the external bus at any address and any `ea_pin` level.
- R11: A request is accepted only when the controller is idle. A request held during an access has no effect on that access's address, strobe or result, and `done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests an operation |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | Single-cycle completion pulse |
| rdata | output | 8 | Byte returned by fetch or read |
| ea_pin | input | 1 | External-access mode pin, sampled at acceptance |
| rom_req | output | 1 | Request to internal ROM |
| rom_addr | output | 12 | Internal ROM address |
| rom_ack | input | 1 | Internal ROM acknowledge, data valid |
| rom_data | input | 8 | Internal ROM byte |
| addr_hi | output | 8 | Dedicated high address port |
| ad_out | output | 8 | Shared address/data port, outgoing value |
| ad_oe | output | 1 | Output enable for the shared port |
| ad_in | input | 8 | Shared port, incoming value |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Take the clock edge that accepts a request as edge 0. On the external path the `ale` cycle follows edge 0. For writes one setup cycle comes next. Then come `STRB_LEN` strobe cycles, then the recovery cycle that carries `done` and `rdata`, and the controller is idle again after one more edge. An internal ROM fetch raises `done` one cycle after the edge that sees `rom_ack`. The bench drives inputs and samples outputs on the falling clock edge. Each scenario task steps through those cycles one at a time and checks every pin in each of them. On reads it places a wrong byte on `ad_in` in the early strobe cycles and the right byte only in the last one, which shows the sampling edge.

// File: rtl/xmem_pkg.sv
// Package: shared operation codes and sequencer states for the external
// memory bus controller. Assumes a 2-bit operation field from the core.
package xmem_pkg;

    typedef enum logic [1:0] {
        OP_FETCH  = 2'd0,
        OP_DREAD  = 2'd1,
        OP_DWRITE = 2'd2,
        OP_RSVD   = 2'd3
    } xmem_op_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADDR  = 3'd1,
        S_SETUP = 3'd2,
        S_STRB  = 3'd3,
        S_REC   = 3'd4,
        S_ROM   = 3'd5
    } xmem_state_e;

endpackage

// File: rtl/xmem_route.sv
// Module: xmem_route
// Decides whether an incoming request is served by the internal ROM port
// or by the external bus. Only code fetches with the mode pin high and an
// address below the on-chip ROM size go to the ROM. Purely combinational;
// assumes the caller samples the result together with the request.
module xmem_route
    import xmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int ROM_BYTES = 4096
) (
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ea,
    output logic              use_rom
);
    localparam logic [ADDR_W-1:0] ROM_LIMIT = ADDR_W'(ROM_BYTES);

    // Route: code below the ROM limit with the mode pin high stays on chip.
    always_comb begin
        use_rom = (xmem_op_e'(op) == OP_FETCH) && ea && (addr < ROM_LIMIT);
    end
endmodule

// File: rtl/xmem_seq.sv
// Module: xmem_seq
// Access sequencer. It accepts one request while idle and then steps
// through the address, optional write setup, strobe, and recovery phases,
// or it waits on the internal ROM handshake. It captures the returned byte
// and issues a one-cycle done pulse. Assumes STRB_LEN >= 1.
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int STRB_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              use_rom,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              rom_ack,
    input  logic [DATA_W-1:0] rom_data,
    output xmem_state_e       state,
    output xmem_op_e          op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    localparam int              CNT_W    = (STRB_LEN > 1) ? $clog2(STRB_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_LEN - 1);

    logic [CNT_W-1:0] cnt;
    logic             accept;

    // Acceptance: only in idle and only for a defined operation.
    always_comb begin
        accept = (state == S_IDLE) && req_valid && (xmem_op_e'(req_op) != OP_RSVD);
    end

    // Phase sequencing, request capture, read capture and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_FETCH;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata   <= '0;
            done    <= 1'b0;
            cnt     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        op_q    <= xmem_op_e'(req_op);
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        state   <= use_rom ? S_ROM : S_ADDR;
                    end
                end
                S_ADDR: begin
                    cnt   <= '0;
                    state <= (op_q == OP_DWRITE) ? S_SETUP : S_STRB;
                end
                S_SETUP: begin
                    cnt   <= '0;
                    state <= S_STRB;
                end
                S_STRB: begin
                    if (cnt == CNT_LAST) begin
                        if (op_q != OP_DWRITE) begin
                            rdata <= ad_in;
                        end
                        done  <= 1'b1;
                        state <= S_REC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_REC: begin
                    state <= S_IDLE;
                end
                S_ROM: begin
                    if (rom_ack) begin
                        rdata <= rom_data;
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11: done is a single-cycle pulse.
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: the captured address cannot change while an access is under way.
    p_busy_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(addr_q));

    // R9: the ROM request holds its address until acknowledged.
    p_rom_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ROM && !rom_ack) |=> (state == S_ROM) && $stable(addr_q));
endmodule

// File: rtl/xmem_pins.sv
// Module: xmem_pins
// Pin driver. It decodes the sequencer phase into the address latch
// strobe, the three memory strobes, the shared port drive and the ROM
// request. Outputs are decoded from registered state. The address latch
// phase and every strobe phase are separate states, so they cannot coincide.
module xmem_pins
    import xmem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_BYTES = 4096
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  xmem_state_e                  state,
    input  xmem_op_e                     op_q,
    input  logic [ADDR_W-1:0]            addr_q,
    input  logic [DATA_W-1:0]            wdata_q,
    output logic [ADDR_W-DATA_W-1:0]     addr_hi,
    output logic [DATA_W-1:0]            ad_out,
    output logic                         ad_oe,
    output logic                         ale,
    output logic                         psen_n,
    output logic                         rd_n,
    output logic                         wr_n,
    output logic                         rom_req,
    output logic [$clog2(ROM_BYTES)-1:0] rom_addr
);
    localparam int ROM_AW = $clog2(ROM_BYTES);

    logic ext_busy;
    logic is_wr;

    // Phase classification used by every pin below.
    always_comb begin
        ext_busy = (state == S_ADDR) || (state == S_SETUP) ||
                   (state == S_STRB) || (state == S_REC);
        is_wr    = (op_q == OP_DWRITE);
    end

    // Address ports and latch strobe.
    always_comb begin
        ale     = (state == S_ADDR);
        addr_hi = ext_busy ? addr_q[ADDR_W-1:DATA_W] : '0;
    end

    // Shared port: low address in the latch phase, write byte from setup to recovery.
    always_comb begin
        if (state == S_ADDR) begin
            ad_out = addr_q[DATA_W-1:0];
            ad_oe  = 1'b1;
        end else if (is_wr && (state == S_SETUP || state == S_STRB || state == S_REC)) begin
            ad_out = wdata_q;
            ad_oe  = 1'b1;
        end else begin
            ad_out = '0;
            ad_oe  = 1'b0;
        end
    end

    // Memory strobes: one per operation, low only in the strobe phase.
    always_comb begin
        psen_n = !((state == S_STRB) && (op_q == OP_FETCH));
        rd_n   = !((state == S_STRB) && (op_q == OP_DREAD));
        wr_n   = !((state == S_STRB) && is_wr);
    end

    // Internal ROM request.
    always_comb begin
        rom_req  = (state == S_ROM);
        rom_addr = addr_q[ROM_AW-1:0];
    end

    // R4: program and data strobes are mutually exclusive.
    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    // R4: the program strobe is high in the cycle before a data strobe falls.
    p_psen_before_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(psen_n));

    // R5: the address latch strobe never overlaps a memory strobe.
    p_ale_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));

    // R6: the shared port is released while a read or fetch strobe is low.
    p_read_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !psen_n) |-> !ad_oe);

    // R7: write data is already driven, unchanged, when the write strobe falls.
    p_wr_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |-> ($past(ad_oe) && ad_oe && $stable(ad_out)));

    // R7: write data stays driven, unchanged, when the write strobe rises.
    p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));

    // R9: no external activity while the internal ROM is being read.
    p_rom_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |-> (!ale && psen_n && rd_n && wr_n && !ad_oe));
endmodule

// File: rtl/xmem_bus_ctrl.sv
// Module: xmem_bus_ctrl (top)
// External memory bus controller with a multiplexed low address/data
// port. It connects the routing decision, the access sequencer and the pin
// driver. Assumes ADDR_W > DATA_W and ROM_BYTES a power of two that is no
// larger than the address space.
module xmem_bus_ctrl #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int ROM_BYTES = 4096,
    parameter int STRB_LEN  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         done,
    output logic [DATA_W-1:0]            rdata,
    input  logic                         ea_pin,
    output logic                         rom_req,
    output logic [$clog2(ROM_BYTES)-1:0] rom_addr,
    input  logic                         rom_ack,
    input  logic [DATA_W-1:0]            rom_data,
    output logic [ADDR_W-DATA_W-1:0]     addr_hi,
    output logic [DATA_W-1:0]            ad_out,
    output logic                         ad_oe,
    input  logic [DATA_W-1:0]            ad_in,
    output logic                         ale,
    output logic                         psen_n,
    output logic                         rd_n,
    output logic                         wr_n
);
    import xmem_pkg::*;

    logic              use_rom;
    xmem_state_e       state;
    xmem_op_e          op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    xmem_route #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_route (
        .op      (req_op),
        .addr    (req_addr),
        .ea      (ea_pin),
        .use_rom (use_rom)
    );

    xmem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRB_LEN(STRB_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .use_rom   (use_rom),
        .ad_in     (ad_in),
        .rom_ack   (rom_ack),
        .rom_data  (rom_data),
        .state     (state),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .rdata     (rdata),
        .done      (done)
    );

    xmem_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_BYTES(ROM_BYTES)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .op_q     (op_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .addr_hi  (addr_hi),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .ale      (ale),
        .psen_n   (psen_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .rom_req  (rom_req),
        .rom_addr (rom_addr)
    );
endmodule

// File: tb/test_xmem_bus_ctrl.sv
// Directed bench for xmem_bus_ctrl. Inputs are driven and outputs sampled
// on the falling clock edge. Each task runs one scenario and checks it.
module test_xmem_bus_ctrl;
    localparam int STRB = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        done;
    logic [7:0]  rdata;
    logic        ea_pin = 1'b0;
    logic        rom_req;
    logic [11:0] rom_addr;
    logic        rom_ack = 1'b0;
    logic [7:0]  rom_data = 8'h0;
    logic [7:0]  addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = 8'h0;
    logic        ale;
    logic        psen_n;
    logic        rd_n;
    logic        wr_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    xmem_bus_ctrl #(.STRB_LEN(STRB)) i_xmem_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .ea_pin(ea_pin), .rom_req(rom_req), .rom_addr(rom_addr), .rom_ack(rom_ack),
        .rom_data(rom_data), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // Strobe vector {psen_n, rd_n, wr_n} expected for a strobe-low cycle of op.
    function automatic logic [2:0] strobe_low(input logic [1:0] op);
        case (op)
            2'd0:    return 3'b011;
            2'd1:    return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    // External access, entered and left on a falling edge with the bus idle.
    // With poke set, a different request stays raised during the access (R11).
    task automatic ext_access(input logic [1:0] op, input logic [15:0] addr,
                              input logic [7:0] wd, input logic [7:0] rd_exp,
                              input bit poke, input string tag);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        if (poke) begin
            req_op = 2'd2; req_addr = 16'h7777; req_wdata = 8'hEE;
        end else begin
            req_valid = 1'b0;
        end
        // R2: address latch cycle
        chk({tag, " R2 ale high"}, ale, 1);
        chk({tag, " R2 addr_hi"}, addr_hi, addr[15:8]);
        chk({tag, " R2 ad_out low address"}, ad_out, addr[7:0]);
        chk({tag, " R2 ad_oe"}, ad_oe, 1);
        chk({tag, " R5 strobes high during ale"}, {psen_n, rd_n, wr_n}, 3'b111);
        if (op == 2'd2) begin
            @(negedge clk);
            // R7: setup cycle before the write strobe
            chk({tag, " R7 setup ale low"}, ale, 0);
            chk({tag, " R7 setup strobes high"}, {psen_n, rd_n, wr_n}, 3'b111);
            chk({tag, " R7 setup drive"}, {ad_oe, ad_out}, {1'b1, wd});
        end
        for (int i = 0; i < STRB; i++) begin
            @(negedge clk);
            if (op != 2'd2) ad_in = (i == STRB - 1) ? rd_exp : ~rd_exp;
            // R3/R4: exactly the strobe that belongs to the operation is low
            chk({tag, " R3 R4 strobe select"}, {psen_n, rd_n, wr_n}, strobe_low(op));
            chk({tag, " R5 ale low during strobe"}, ale, 0);
            chk({tag, " R2 addr_hi held"}, addr_hi, addr[15:8]);
            chk({tag, " R11 no done during strobe"}, done, 0);
            if (op == 2'd2) chk({tag, " R7 write data held"}, {ad_oe, ad_out}, {1'b1, wd});
            else            chk({tag, " R6 port released"}, ad_oe, 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        // Recovery cycle
        chk({tag, " R4 strobes back high"}, {psen_n, rd_n, wr_n}, 3'b111);
        chk({tag, " R6 R7 done pulse"}, done, 1);
        if (op == 2'd2) begin
            chk({tag, " R7 data held after wr rises"}, {ad_oe, ad_out}, {1'b1, wd});
        end else begin
            chk({tag, " R6 rdata from last strobe edge"}, rdata, rd_exp);
            chk({tag, " R6 port released in recovery"}, ad_oe, 0);
        end
        @(negedge clk);
        chk({tag, " R11 done single cycle"}, done, 0);
        chk({tag, " R7 port released after access"}, ad_oe, 0);
        chk({tag, " R11 idle, no new latch"}, ale, 0);
    endtask

    // Internal ROM fetch with a chosen number of wait cycles before ack.
    task automatic rom_fetch(input logic [15:0] addr, input logic [7:0] d,
                             input int waits, input string tag);
        req_valid = 1'b1; req_op = 2'd0; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i <= waits; i++) begin
            chk({tag, " R9 rom_req"}, rom_req, 1);
            chk({tag, " R9 rom_addr"}, rom_addr, addr[11:0]);
            chk({tag, " R9 no external activity"},
                {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
            chk({tag, " R9 no done before ack"}, done, 0);
            if (i == waits) begin
                rom_ack = 1'b1; rom_data = d;
            end
            @(negedge clk);
        end
        rom_ack = 1'b0; rom_data = ~d;
        chk({tag, " R9 done after ack"}, done, 1);
        chk({tag, " R9 rdata from rom"}, rdata, d);
        chk({tag, " R9 rom_req dropped"}, rom_req, 0);
        @(negedge clk);
        chk({tag, " R11 done single cycle"}, done, 0);
    endtask

    // Code fetch whose routing the bench predicts from the mode pin and address.
    task automatic fetch(input logic ea, input logic [15:0] addr, input logic [7:0] d,
                         input string tag);
        ea_pin = ea;
        if (ea && addr < 16'h1000) rom_fetch(addr, d, 1, tag);
        else                       ext_access(2'd0, addr, 8'h00, d, 1'b0, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset ale/strobes/oe/done/rom_req",
            {ale, psen_n, rd_n, wr_n, ad_oe, done, rom_req}, 7'b0111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset",
            {ale, psen_n, rd_n, wr_n, ad_oe, done, rom_req}, 7'b0111000);
    endtask

    task automatic t_reserved;
        req_valid = 1'b1; req_op = 2'd3; req_addr = 16'h0042;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 reserved op ignored",
                {ale, psen_n, rd_n, wr_n, ad_oe, done, rom_req}, 7'b0111000);
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        fetch(1'b0, 16'h0010, 8'h3C, "R8 ea low fetch 0x0010");
        fetch(1'b1, 16'h0FFF, 8'hA5, "R9 ea high fetch 0x0FFF");
        fetch(1'b1, 16'h1000, 8'h5A, "R10 ea high fetch 0x1000");
        fetch(1'b1, 16'hFFFF, 8'h81, "R10 ea high fetch 0xFFFF");
        ea_pin = 1'b1;
        ext_access(2'd1, 16'h0020, 8'h00, 8'hC3, 1'b0, "R10 data read low address");
        ext_access(2'd2, 16'h1234, 8'h96, 8'h00, 1'b0, "R7 write 0x1234");
        ext_access(2'd2, 16'h0ABC, 8'h69, 8'h00, 1'b0, "R10 write low address ea high");
        ext_access(2'd1, 16'h2345, 8'h00, 8'h7E, 1'b1, "R11 read with held request");
        t_reserved();
        rom_fetch(16'h0000, 8'h11, 0, "R9 rom immediate ack");
        ea_pin = 1'b0;
        ext_access(2'd0, 16'h0001, 8'h00, 8'hF0, 1'b0, "R8 ea low fetch 0x0001");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule